// File: doc/BRIEF.md
# Key-Locked Configuration Register Bank

This block is the host-visible register bank of a four-channel device. A host reaches it over a simple synchronous word-addressed bus with separate write and read strobes. The bus has no valid/ready handshake and no back-pressure. Every access completes in the cycle it is presented. Read data appears on the cycle after the read strobe, and it is zero on any cycle that follows no read.

The address space has three kinds of group. Each group spans 64 words and is selected by the address bits above bit 5:
- a generic group at 0x000 holds a fixed identity word, a revision word, a scratch word, the lock word, the write-error flag and the soft-reset pulse bit;
- a device group at 0x040 holds device-wide control, configuration, status and pulse registers;
- four channel groups at 0x080 + ch*0x40 share one layout.

Any write outside the scratch, lock and error words is refused unless the lock word holds the key 0xA001. A refused write leaves state untouched and raises a sticky error flag.

Control outputs, pulse outputs and status inputs connect to datapath logic outside this block.

Top module: `cfg_lock_regbank`

## Requirements
- R1: After hard reset the lock word (0x003) reads 0x0000 and the error word (0x004) reads 0. Device control is 0x0003 and every channel control is 0x0010. All configuration fields are 0.
- R2: A read strobe at one clock edge puts the addressed word on `rdata` in the following cycle, and `rdata` is 0 in any cycle not preceded by a read. Word 0x000 returns the identity value 0x3C5A and word 0x001 returns the revision value 0x0102.
- R3: A write to device or channel registers, or to the soft-reset word, changes state only while the lock word equals 0xA001. `unlocked` is high exactly when it does.
- R4: The scratch word (0x002), the lock word (0x003) and the error word (0x004) accept writes whatever the lock holds.
- R5: A write refused by R3 sets bit 0 of the error word and `wr_err`. The flag stays set until a write to 0x004 with bit 0 at 1 clears it. A write there with bit 0 at 0 leaves it set.
- R6: The following all read as 0: unused bits, unused offsets, the unused address blocks 0x180 to 0x1FF, and the pulse words. A configuration word (offset 3 of a group) keeps only bits 7:0.
- R7: A permitted write of pattern P to a pulse word (offset 2 of a group) drives P[3:0] on that group's pulse output for exactly the one cycle after the write edge. The output is 0 otherwise.
- R8: A permitted write with bit 0 at 1 to word 0x005 has the following effects at that edge. Control and configuration registers return to their defaults, the lock returns to 0x0000 and the error flag clears. The scratch word keeps its value. `soft_rst` is high for the following cycle.
- R9: Channel ch uses offsets 0 (control), 1 (status) and 3 (configuration) at base 0x080 + ch*0x40, and the device group uses the same offsets at 0x040. Status words return the live status inputs.
- R10: While unlocked, writes to read-only words (identity, revision, status) change nothing and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 9 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, one cycle after the read strobe |
| dev_status | input | 16 | Device status value |
| ch_status | input | 64 | Channel status values, channel ch in bits ch*16+15:ch*16 |
| dev_ctrl | output | 16 | Device control register |
| dev_cfg | output | 8 | Device configuration field |
| dev_pulse | output | 4 | Device pulse bits |
| ch_ctrl | output | 64 | Channel control registers, 16 bits each |
| ch_cfg | output | 32 | Channel configuration fields, 8 bits each |
| ch_pulse | output | 16 | Channel pulse bits, 4 each |
| wr_err | output | 1 | Sticky write-error flag |
| unlocked | output | 1 | Lock word holds the key |
| soft_rst | output | 1 | One-cycle soft-reset pulse |

## Verification
The assertions assume that both strobes are low during hard reset. Their checks on a refused write hold because a soft-reset write can never also select a device or channel group: one address reaches one group. The stimulus raises one strobe per cycle, changes inputs only between clock edges, and alters status inputs only while no read is pending. A behavioural model then predicts every output on every cycle.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;
  localparam int OFFW = 6;

  // generic group offsets
  localparam logic [OFFW-1:0] G_ID   = 6'd0;
  localparam logic [OFFW-1:0] G_REV  = 6'd1;
  localparam logic [OFFW-1:0] G_SCR  = 6'd2;
  localparam logic [OFFW-1:0] G_LOCK = 6'd3;
  localparam logic [OFFW-1:0] G_ERR  = 6'd4;
  localparam logic [OFFW-1:0] G_RST  = 6'd5;

  // device and channel group offsets
  localparam logic [OFFW-1:0] R_CTRL  = 6'd0;
  localparam logic [OFFW-1:0] R_STAT  = 6'd1;
  localparam logic [OFFW-1:0] R_PULSE = 6'd2;
  localparam logic [OFFW-1:0] R_CFG   = 6'd3;

  typedef enum logic [1:0] {BLK_GEN, BLK_DEV, BLK_CHAN, BLK_NONE} blk_e;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_regbank_pkg::*;
#(
  parameter int AW  = 9,
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [AW-1:0]   addr_i,
  output blk_e            blk_o,
  output logic [CHW-1:0]  ch_o,
  output logic [OFFW-1:0] off_o
);
  localparam int BW = AW - OFFW;

  logic [BW-1:0] grp;
  assign grp   = addr_i[AW-1:OFFW];
  assign off_o = addr_i[OFFW-1:0];

  always_comb begin
    blk_o = BLK_NONE;
    ch_o  = '0;
    if (int'(grp) == 0) begin
      blk_o = BLK_GEN;
    end else if (int'(grp) == 1) begin
      blk_o = BLK_DEV;
    end else if (int'(grp) < 2 + NCH) begin
      blk_o = BLK_CHAN;
      ch_o  = CHW'(int'(grp) - 2);
    end
  end
endmodule

// File: rtl/cfg_lock_guard.sv
module cfg_lock_guard
  import cfg_regbank_pkg::*;
#(
  parameter int            DW      = 16,
  parameter logic [DW-1:0] KEY     = 16'hA001,
  parameter logic [DW-1:0] ID_VAL  = 16'h3C5A,
  parameter logic [DW-1:0] REV_VAL = 16'h0102
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic            gen_sel_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            unlocked_o,
  output logic            prot_we_o,
  output logic            soft_req_o,
  output logic            soft_pulse_o,
  output logic            err_o,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] lock_q, scratch_q;
  logic          err_q, soft_q;
  logic          exempt, denied;

  assign exempt     = gen_sel_i && (off_i == G_SCR || off_i == G_LOCK || off_i == G_ERR);
  assign unlocked_o = (lock_q == KEY);
  assign prot_we_o  = wr_en_i && !exempt && unlocked_o;
  assign denied     = wr_en_i && !exempt && !unlocked_o;
  assign soft_req_o = prot_we_o && gen_sel_i && off_i == G_RST && wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (soft_req_o) begin
      lock_q <= '0;
    end else if (wr_en_i && gen_sel_i && off_i == G_LOCK) begin
      lock_q <= wdata_i;
    end
  end

  // scratch only sees hard reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
    end else if (wr_en_i && gen_sel_i && off_i == G_SCR) begin
      scratch_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (soft_req_o) begin
      err_q <= 1'b0;
    end else if (denied) begin
      err_q <= 1'b1;
    end else if (wr_en_i && gen_sel_i && off_i == G_ERR && wdata_i[0]) begin
      err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= 1'b0;
    else        soft_q <= soft_req_o;
  end

  assign soft_pulse_o = soft_q;
  assign err_o        = err_q;

  always_comb begin
    unique case (off_i)
      G_ID:    rdata_o = ID_VAL;
      G_REV:   rdata_o = REV_VAL;
      G_SCR:   rdata_o = scratch_q;
      G_LOCK:  rdata_o = lock_q;
      G_ERR:   rdata_o = {{(DW-1){1'b0}}, err_q};
      default: rdata_o = '0;
    endcase
  end

  AST_ERR_ON_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    denied |=> err_q); // R5
  AST_SOFT_CLEARS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    soft_req_o |=> (lock_q == '0 && !err_q && soft_q)); // R8
  AST_SCRATCH_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && gen_sel_i && off_i == G_SCR) |=> (scratch_q == $past(wdata_i))); // R4
endmodule

// File: rtl/cfg_reg_group.sv
module cfg_reg_group
  import cfg_regbank_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            PW       = 4,
  parameter int            CFGW     = 8,
  parameter logic [DW-1:0] CTRL_DEF = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_i,
  input  logic            wr_req_i,
  input  logic            we_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   status_i,
  output logic [DW-1:0]   ctrl_o,
  output logic [CFGW-1:0] cfg_o,
  output logic [PW-1:0]   pulse_o,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0]   ctrl_q;
  logic [CFGW-1:0] cfg_q;
  logic [PW-1:0]   pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEF;
      cfg_q  <= '0;
    end else if (soft_i) begin
      ctrl_q <= CTRL_DEF;
      cfg_q  <= '0;
    end else if (we_i) begin
      if (off_i == R_CTRL) ctrl_q <= wdata_i;
      if (off_i == R_CFG)  cfg_q  <= wdata_i[CFGW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pulse_q <= '0;
    else if (we_i && off_i == R_PULSE) pulse_q <= wdata_i[PW-1:0];
    else                               pulse_q <= '0;
  end

  assign ctrl_o  = ctrl_q;
  assign cfg_o   = cfg_q;
  assign pulse_o = pulse_q;

  always_comb begin
    unique case (off_i)
      R_CTRL:  rdata_o = ctrl_q;
      R_STAT:  rdata_o = status_i;
      R_CFG:   rdata_o = {{(DW-CFGW){1'b0}}, cfg_q};
      default: rdata_o = '0;
    endcase
  end

  AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_i && !we_i && !soft_i) |=> ($stable(ctrl_q) && $stable(cfg_q))); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_q) |-> $past(we_i)); // R7
endmodule

// File: rtl/cfg_lock_regbank.sv
module cfg_lock_regbank
  import cfg_regbank_pkg::*;
#(
  parameter int            NCH          = 4,
  parameter int            DW           = 16,
  parameter int            AW           = 9,
  parameter int            PW           = 4,
  parameter int            CFGW         = 8,
  parameter logic [DW-1:0] KEY          = 16'hA001,
  parameter logic [DW-1:0] ID_VAL       = 16'h3C5A,
  parameter logic [DW-1:0] REV_VAL      = 16'h0102,
  parameter logic [DW-1:0] DEV_CTRL_DEF = 16'h0003,
  parameter logic [DW-1:0] CH_CTRL_DEF  = 16'h0010
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  input  logic [DW-1:0]       dev_status,
  input  logic [NCH*DW-1:0]   ch_status,
  output logic [DW-1:0]       dev_ctrl,
  output logic [CFGW-1:0]     dev_cfg,
  output logic [PW-1:0]       dev_pulse,
  output logic [NCH*DW-1:0]   ch_ctrl,
  output logic [NCH*CFGW-1:0] ch_cfg,
  output logic [NCH*PW-1:0]   ch_pulse,
  output logic                wr_err,
  output logic                unlocked,
  output logic                soft_rst
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  blk_e            blk;
  logic [CHW-1:0]  ch;
  logic [OFFW-1:0] off;
  logic            prot_we, soft_req, gen_sel, dev_sel;
  logic [DW-1:0]   gen_rd, dev_rd, mux_rd, rdata_q;
  logic [DW-1:0]   ch_rd [NCH];

  cfg_addr_decode #(.AW(AW), .NCH(NCH), .CHW(CHW)) u_dec (
    .addr_i(addr), .blk_o(blk), .ch_o(ch), .off_o(off)
  );

  assign gen_sel = (blk == BLK_GEN);
  assign dev_sel = (blk == BLK_DEV);

  cfg_lock_guard #(.DW(DW), .KEY(KEY), .ID_VAL(ID_VAL), .REV_VAL(REV_VAL)) u_guard (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .gen_sel_i(gen_sel), .off_i(off),
    .wdata_i(wdata), .unlocked_o(unlocked), .prot_we_o(prot_we), .soft_req_o(soft_req),
    .soft_pulse_o(soft_rst), .err_o(wr_err), .rdata_o(gen_rd)
  );

  cfg_reg_group #(.DW(DW), .PW(PW), .CFGW(CFGW), .CTRL_DEF(DEV_CTRL_DEF)) u_dev (
    .clk(clk), .rst_n(rst_n), .soft_i(soft_req), .wr_req_i(wr_en && dev_sel),
    .we_i(prot_we && dev_sel), .off_i(off), .wdata_i(wdata), .status_i(dev_status),
    .ctrl_o(dev_ctrl), .cfg_o(dev_cfg), .pulse_o(dev_pulse), .rdata_o(dev_rd)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    logic sel;
    assign sel = (blk == BLK_CHAN) && (ch == CHW'(gi));
    cfg_reg_group #(.DW(DW), .PW(PW), .CFGW(CFGW), .CTRL_DEF(CH_CTRL_DEF)) u_grp (
      .clk(clk), .rst_n(rst_n), .soft_i(soft_req), .wr_req_i(wr_en && sel),
      .we_i(prot_we && sel), .off_i(off), .wdata_i(wdata),
      .status_i(ch_status[gi*DW +: DW]),
      .ctrl_o(ch_ctrl[gi*DW +: DW]), .cfg_o(ch_cfg[gi*CFGW +: CFGW]),
      .pulse_o(ch_pulse[gi*PW +: PW]), .rdata_o(ch_rd[gi])
    );
  end

  always_comb begin
    unique case (blk)
      BLK_GEN:  mux_rd = gen_rd;
      BLK_DEV:  mux_rd = dev_rd;
      BLK_CHAN: mux_rd = ch_rd[ch];
      default:  mux_rd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= mux_rd;
    else            rdata_q <= '0;
  end

  assign rdata = rdata_q;

  AST_UNUSED_BLOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && blk == BLK_NONE) |=> (rdata == '0)); // R6
  AST_SOFT_ONLY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> $past(unlocked)); // R3
endmodule

// File: tb/test_cfg_lock_regbank.sv
module test_cfg_lock_regbank;
  localparam int NCH = 4;
  localparam logic [15:0] KEYV = 16'hA001;
  localparam logic [15:0] IDV = 16'h3C5A, REVV = 16'h0102;
  localparam logic [15:0] DDEF = 16'h0003, CDEF = 16'h0010;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0] addr = '0;
  logic [15:0] wdata = '0, dev_status = 16'h0000;
  logic [NCH*16-1:0] ch_status = '0;
  logic [15:0] rdata, dev_ctrl;
  logic [7:0] dev_cfg;
  logic [3:0] dev_pulse;
  logic [NCH*16-1:0] ch_ctrl;
  logic [NCH*8-1:0] ch_cfg;
  logic [NCH*4-1:0] ch_pulse;
  logic wr_err, unlocked, soft_rst;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_lock_regbank i_cfg_lock_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dev_status(dev_status), .ch_status(ch_status), .dev_ctrl(dev_ctrl),
    .dev_cfg(dev_cfg), .dev_pulse(dev_pulse), .ch_ctrl(ch_ctrl), .ch_cfg(ch_cfg),
    .ch_pulse(ch_pulse), .wr_err(wr_err), .unlocked(unlocked), .soft_rst(soft_rst)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_lock, m_scr, m_dctrl, m_rdata;
  logic [7:0]  m_dcfg;
  logic [3:0]  m_dpulse;
  logic        m_err, m_soft;
  logic [15:0] m_cctrl [NCH];
  logic [7:0]  m_ccfg  [NCH];
  logic [3:0]  m_cpulse[NCH];

  function automatic logic [15:0] m_read(input logic [8:0] a);
    int b = int'(a) / 64, o = int'(a) % 64;
    if (b == 0) begin
      case (o)
        0: return IDV;
        1: return REVV;
        2: return m_scr;
        3: return m_lock;
        4: return {15'd0, m_err};
        default: return 16'h0;
      endcase
    end else if (b == 1) begin
      case (o)
        0: return m_dctrl;
        1: return dev_status;
        3: return {8'd0, m_dcfg};
        default: return 16'h0;
      endcase
    end else if (b < 2 + NCH) begin
      case (o)
        0: return m_cctrl[b-2];
        1: return ch_status[(b-2)*16 +: 16];
        3: return {8'd0, m_ccfg[b-2]};
        default: return 16'h0;
      endcase
    end
    return 16'h0;
  endfunction

  always @(posedge clk) begin
    int b, o;
    if (!rst_n) begin
      m_lock = 0; m_scr = 0; m_dctrl = DDEF; m_dcfg = 0; m_err = 0; m_rdata = 0;
      m_dpulse = 0; m_soft = 0;
      for (int k = 0; k < NCH; k++) begin m_cctrl[k] = CDEF; m_ccfg[k] = 0; m_cpulse[k] = 0; end
    end else begin
      m_rdata = rd_en ? m_read(addr) : 16'h0;
      m_dpulse = 0; m_soft = 0;
      for (int k = 0; k < NCH; k++) m_cpulse[k] = 0;
      if (wr_en) begin
        b = int'(addr) / 64; o = int'(addr) % 64;
        if (b == 0 && o == 2) m_scr = wdata;
        else if (b == 0 && o == 3) m_lock = wdata;
        else if (b == 0 && o == 4) begin if (wdata[0]) m_err = 0; end
        else if (m_lock != KEYV) m_err = 1;
        else if (b == 0 && o == 5) begin
          if (wdata[0]) begin
            m_soft = 1; m_lock = 0; m_err = 0; m_dctrl = DDEF; m_dcfg = 0;
            for (int k = 0; k < NCH; k++) begin m_cctrl[k] = CDEF; m_ccfg[k] = 0; end
          end
        end else if (b == 1) begin
          if (o == 0) m_dctrl = wdata;
          if (o == 2) m_dpulse = wdata[3:0];
          if (o == 3) m_dcfg = wdata[7:0];
        end else if (b >= 2 && b < 2 + NCH) begin
          if (o == 0) m_cctrl[b-2] = wdata;
          if (o == 2) m_cpulse[b-2] = wdata[3:0];
          if (o == 3) m_ccfg[b-2] = wdata[7:0];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "model rdata", 64'(rdata), 64'(m_rdata));
      chk("R3", "model dev_ctrl", 64'(dev_ctrl), 64'(m_dctrl));
      chk("R3", "model unlocked", 64'(unlocked), 64'(m_lock == KEYV));
      chk("R5", "model wr_err", 64'(wr_err), 64'(m_err));
      chk("R7", "model dev_pulse", 64'(dev_pulse), 64'(m_dpulse));
      chk("R8", "model soft_rst", 64'(soft_rst), 64'(m_soft));
      chk("R6", "model dev_cfg", 64'(dev_cfg), 64'(m_dcfg));
      for (int k = 0; k < NCH; k++) begin
        chk("R9", "model ch_ctrl", 64'(ch_ctrl[k*16 +: 16]), 64'(m_cctrl[k]));
        chk("R9", "model ch_cfg", 64'(ch_cfg[k*8 +: 8]), 64'(m_ccfg[k]));
        chk("R7", "model ch_pulse", 64'(ch_pulse[k*4 +: 4]), 64'(m_cpulse[k]));
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [15:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk); #1;
    rd_en = 1'b0;
    chk(tag, $sformatf("read %h", a), 64'(rdata), 64'(exp));
  endtask

  task automatic idle();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle();
    // R1 reset state
    rd(9'h003, 16'h0000, "R1");
    rd(9'h004, 16'h0000, "R1");
    chk("R1", "dev_ctrl reset", 64'(dev_ctrl), 64'(DDEF));
    for (int k = 0; k < NCH; k++) chk("R1", "ch_ctrl reset", 64'(ch_ctrl[k*16 +: 16]), 64'(CDEF));
    rd(9'h0C3, 16'h0000, "R1");
    // R2 fixed words and idle read data
    rd(9'h000, IDV, "R2");
    rd(9'h001, REVV, "R2");
    idle();
    chk("R2", "idle rdata", 64'(rdata), 64'h0);
    // locked write refused
    wr(9'h040, 16'h1234);
    chk("R5", "err after denied", 64'(wr_err), 64'h1);
    chk("R3", "dev_ctrl kept", 64'(dev_ctrl), 64'(DDEF));
    wr(9'h002, 16'hBEEF);
    rd(9'h002, 16'hBEEF, "R4");
    wr(9'h004, 16'h0000);
    chk("R5", "err kept on zero write", 64'(wr_err), 64'h1);
    wr(9'h004, 16'h0001);
    chk("R5", "err cleared", 64'(wr_err), 64'h0);
    // wrong key
    wr(9'h003, 16'hA000);
    wr(9'h080, 16'h5555);
    chk("R3", "ch0 ctrl wrong key", 64'(ch_ctrl[15:0]), 64'(CDEF));
    chk("R5", "err wrong key", 64'(wr_err), 64'h1);
    wr(9'h003, KEYV);
    chk("R3", "unlocked", 64'(unlocked), 64'h1);
    rd(9'h003, KEYV, "R4");
    wr(9'h004, 16'h0001);
    // unlocked writes
    wr(9'h040, 16'h1234);
    rd(9'h040, 16'h1234, "R3");
    dev_status = 16'h9ABC;
    rd(9'h041, 16'h9ABC, "R9");
    for (int k = 0; k < NCH; k++) begin
      ch_status[k*16 +: 16] = 16'hC000 + 16'(k);
      wr(9'(128 + k*64), 16'h1000 + 16'(k));
      wr(9'(128 + k*64 + 3), 16'hAB30 + 16'(k));
    end
    for (int k = 0; k < NCH; k++) begin
      rd(9'(128 + k*64), 16'h1000 + 16'(k), "R9");
      rd(9'(128 + k*64 + 1), 16'hC000 + 16'(k), "R9");
      rd(9'(128 + k*64 + 3), 16'h0030 + 16'(k), "R6");
    end
    // unused and pulse reads
    rd(9'h007, 16'h0, "R6");
    rd(9'h045, 16'h0, "R6");
    rd(9'h0C5, 16'h0, "R6");
    rd(9'h180, 16'h0, "R6");
    rd(9'h1C3, 16'h0, "R6");
    rd(9'h042, 16'h0, "R6");
    rd(9'h005, 16'h0, "R6");
    // read-only writes while unlocked
    wr(9'h000, 16'hFFFF);
    wr(9'h041, 16'hFFFF);
    rd(9'h000, IDV, "R10");
    rd(9'h041, 16'h9ABC, "R10");
    chk("R10", "no err on ro write", 64'(wr_err), 64'h0);
    // pulses
    wr(9'h042, 16'h0005);
    chk("R7", "dev pulse high", 64'(dev_pulse), 64'h5);
    idle();
    chk("R7", "dev pulse low", 64'(dev_pulse), 64'h0);
    wr(9'h102, 16'h000A);
    chk("R7", "ch2 pulse", 64'(ch_pulse), 64'h0A00);
    idle();
    chk("R7", "ch2 pulse low", 64'(ch_pulse), 64'h0);
    // soft reset
    wr(9'h002, 16'h7777);
    wr(9'h043, 16'h00EE);
    wr(9'h005, 16'h0001);
    chk("R8", "soft_rst high", 64'(soft_rst), 64'h1);
    chk("R8", "dev_ctrl default", 64'(dev_ctrl), 64'(DDEF));
    chk("R8", "dev_cfg default", 64'(dev_cfg), 64'h0);
    idle();
    chk("R8", "soft_rst low", 64'(soft_rst), 64'h0);
    rd(9'h003, 16'h0000, "R8");
    rd(9'h002, 16'h7777, "R8");
    rd(9'h143, 16'h0000, "R8");
    // locked again: pulse write refused
    wr(9'h042, 16'h000F);
    chk("R7", "denied pulse", 64'(dev_pulse), 64'h0);
    chk("R5", "err after relock", 64'(wr_err), 64'h1);
    idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule